// File: doc/BRIEF.md
# Aligned Load/Store Unit

This unit connects a 32-bit register datapath to a data memory that is organised as 32-bit words. It accepts one request at a time. Each request is a word load, a word store, a byte load or a byte store. The unit adds a base register value to a signed 16-bit displacement to form a byte address. A word access that does not fall on a 4-byte boundary is refused with a fault, and that request never reaches the memory. Byte accesses are legal at every address. For byte accesses the unit steers data through the matching byte lane.

Requests use a valid/ready handshake. A store finishes in the cycle it is accepted. A load holds the request side busy while the memory returns its word one cycle later, and then the unit delivers the formatted result for register write-back. A refused word access finishes in its accept cycle, and the unit reports the offending byte address with it.

Top module: `ldst_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits, computed modulo 2^32. `mem_addr` carries bits 31:2 of that address.
- R2: A word request (`req_op` 2'b00 = word load, 2'b01 = word store) whose effective address has bits 1:0 not equal to zero sets `rsp_fault` and `rsp_done` in its accept cycle. In that same cycle `rsp_fault_addr` equals the effective address.
- R3: A faulting request drives neither `mem_en` nor `mem_we`, and the memory contents are unchanged afterwards.
- R4: A byte load (`req_op` 2'b10) returns the byte at the effective address in `rsp_data[7:0]`, with zeros in bits 31:8. Lanes are little-endian: address bits 1:0 = 0 select memory bits 7:0, and 3 selects bits 31:24.
- R5: A byte store (`req_op` 2'b11) asserts exactly one `mem_be` bit, the one at index address[1:0]. It places `req_wdata[7:0]` on all four lanes of `mem_wdata`, and it leaves the other three bytes of the word unchanged.
- R6: A word load drives `mem_en` with `mem_be` = 4'hF in its accept cycle. One cycle later `req_ready` is low, `rsp_done` is high, and `rsp_data` holds the full memory word.
- R7: A word store drives `mem_en`, `mem_we` and `mem_be` = 4'hF with `mem_wdata` = `req_wdata`. It asserts `rsp_done` in the accept cycle, and `req_ready` stays high.
- R8: After reset, `req_ready` is high, and `rsp_done`, `rsp_fault` and `mem_en` are low while no request is valid.
- R9: Byte loads and byte stores never fault, whatever the address alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| rsp_done | output | 1 | Request completed |
| rsp_data | output | 32 | Formatted load result |
| rsp_fault | output | 1 | Misaligned word access |
| rsp_fault_addr | output | 32 | Faulting effective address |

## Verification
These results appear in the accept cycle: the address, enables, lanes and write data, the fault flag and fault address, and the completion of a store. The bench therefore checks them one time unit after it drives the request, before the next rising edge. Load data and busy `req_ready` arrive one edge later, so the bench checks them at the following falling edge, and it removes the request at that same point. The memory model in the bench answers reads after one edge. The bench checks memory contents by loading them back through the unit, which shows both that byte stores left the other lanes intact and that refused stores wrote nothing.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } ldst_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ldst_state_e;
endpackage

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int AW  = 32,
  parameter int IW  = 16,
  parameter int LSB = 2
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] imm,
  input  logic          is_byte,
  output logic [AW-1:0] ea,
  output logic          misaligned
);
  logic [AW-1:0] imm_sx;

  always_comb begin
    imm_sx     = {{(AW-IW){imm[IW-1]}}, imm};
    ea         = base + imm_sx;
    misaligned = !is_byte && (ea[LSB-1:0] != '0);
  end
endmodule

// File: rtl/ldst_steer.sv
module ldst_steer #(
  parameter int DW  = 32,
  parameter int LSB = 2
) (
  input  logic [LSB-1:0]  lane,
  input  logic            is_byte,
  input  logic [DW-1:0]   src,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   wdata
);
  localparam int LANES = DW / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g]          = is_byte ? (lane == LSB'(g)) : 1'b1;
    assign wdata[g*8 +: 8] = is_byte ? src[7:0] : src[g*8 +: 8];
  end
endmodule

// File: rtl/ldst_fmt.sv
module ldst_fmt #(
  parameter int DW  = 32,
  parameter int LSB = 2
) (
  input  logic [DW-1:0]  rdata,
  input  logic [LSB-1:0] lane,
  input  logic           is_byte,
  output logic [DW-1:0]  result
);
  logic [7:0] picked;

  always_comb begin
    picked = rdata[{lane, 3'b000} +: 8];
    result = is_byte ? {{(DW-8){1'b0}}, picked} : rdata;
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [AW-1:0]         req_base,
  input  logic [IW-1:0]         req_imm,
  input  logic [DW-1:0]         req_wdata,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [AW-$clog2(DW/8)-1:0] mem_addr,
  output logic [DW/8-1:0]       mem_be,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  rsp_done,
  output logic [DW-1:0]         rsp_data,
  output logic                  rsp_fault,
  output logic [AW-1:0]         rsp_fault_addr
);
  localparam int LANES = DW / 8;
  localparam int LSB   = $clog2(LANES);

  ldst_state_e    state;
  logic           accept, is_byte, is_store, misaligned;
  logic [AW-1:0]  ea;
  logic [LSB-1:0] lane_q;
  logic           byte_q;
  logic [DW-1:0]  fmt_data;

  assign is_byte  = req_op[1];
  assign is_store = req_op[0];
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  ldst_agu #(.AW(AW), .IW(IW), .LSB(LSB)) agu_i (
    .base(req_base), .imm(req_imm), .is_byte(is_byte),
    .ea(ea), .misaligned(misaligned)
  );

  ldst_steer #(.DW(DW), .LSB(LSB)) steer_i (
    .lane(ea[LSB-1:0]), .is_byte(is_byte), .src(req_wdata),
    .be(mem_be), .wdata(mem_wdata)
  );

  ldst_fmt #(.DW(DW), .LSB(LSB)) fmt_i (
    .rdata(mem_rdata), .lane(lane_q), .is_byte(byte_q), .result(fmt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      lane_q <= '0;
      byte_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept && !misaligned && !is_store) begin
          state  <= ST_WAIT;
          lane_q <= ea[LSB-1:0];
          byte_q <= is_byte;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en         = accept && !misaligned;
    mem_we         = mem_en && is_store;
    mem_addr       = ea[AW-1:LSB];
    rsp_fault      = accept && misaligned;
    rsp_fault_addr = rsp_fault ? ea : '0;
    rsp_done       = (accept && (misaligned || is_store)) || (state == ST_WAIT);
    rsp_data       = (state == ST_WAIT) ? fmt_data : '0;
  end

  // R3: a refused request never reaches memory
  a_r3_fault_no_mem: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> !mem_en && !mem_we);

  // R2: a reported fault address is never word aligned
  a_r2_fault_addr_odd: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_fault_addr[LSB-1:0] != '0) && rsp_done);

  // R6: a read completes on the next cycle with the request side busy
  a_r6_read_done_next: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> rsp_done && !req_ready && !rsp_fault);

  // R5: a byte write enables exactly one lane
  a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_we && req_op == OP_STB) |-> $countones(mem_be) == 1);

  // R9: byte requests are never refused
  a_r9_byte_no_fault: assert property (@(posedge clk) disable iff (rst)
    (accept && is_byte) |-> !rsp_fault);

  // R4: a byte result carries zeros above the low byte
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_en && !mem_we && is_byte)) |-> rsp_data[DW-1:8] == '0);
endmodule

// File: tb/ldst_align_unit_tb_top.sv
module ldst_align_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [31:0] req_base;
  logic [15:0] req_imm;
  logic [31:0] req_wdata;
  logic        mem_en, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_data, rsp_fault_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] mem [16];

  always #10 clk = ~clk;

  ldst_align_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault), .rsp_fault_addr(rsp_fault_addr)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: op, base, imm, src, fault, expect (load data or fault address), lane enables
  localparam int NV = 19;
  localparam bit [118:0] VEC [NV] = '{
    {2'd0, 32'h100, 16'h0008, 32'h0,        1'b0, 32'h0B0A0908, 4'hF},
    {2'd0, 32'h010, 16'hFFFC, 32'h0,        1'b0, 32'h0F0E0D0C, 4'hF},
    {2'd2, 32'h005, 16'h0000, 32'h0,        1'b0, 32'h00000005, 4'h2},
    {2'd2, 32'h008, 16'h0003, 32'h0,        1'b0, 32'h0000000B, 4'h8},
    {2'd0, 32'h002, 16'h0000, 32'h0,        1'b1, 32'h00000002, 4'h0},
    {2'd0, 32'h100, 16'h0001, 32'h0,        1'b1, 32'h00000101, 4'h0},
    {2'd1, 32'h001, 16'hFFFF, 32'hDEADBEEF, 1'b0, 32'h0,        4'hF},
    {2'd0, 32'h000, 16'h0000, 32'h0,        1'b0, 32'hDEADBEEF, 4'hF},
    {2'd3, 32'h000, 16'h0006, 32'h123456A5, 1'b0, 32'h0,        4'h4},
    {2'd0, 32'h004, 16'h0000, 32'h0,        1'b0, 32'h07A50504, 4'hF},
    {2'd1, 32'h003, 16'h0000, 32'hFFFFFFFF, 1'b1, 32'h00000003, 4'h0},
    {2'd0, 32'h000, 16'h0000, 32'h0,        1'b0, 32'hDEADBEEF, 4'hF},
    {2'd2, 32'h006, 16'h0000, 32'h0,        1'b0, 32'h000000A5, 4'h4},
    {2'd2, 32'h000, 16'h0000, 32'h0,        1'b0, 32'h000000EF, 4'h1},
    {2'd3, 32'h00F, 16'h0000, 32'h00000077, 1'b0, 32'h0,        4'h8},
    {2'd0, 32'h00C, 16'h0000, 32'h0,        1'b0, 32'h770E0D0C, 4'hF},
    {2'd2, 32'h007, 16'hFFFE, 32'h0,        1'b0, 32'h00000005, 4'h2},
    {2'd1, 32'h002, 16'h0002, 32'hCAFEF00D, 1'b0, 32'h0,        4'hF},
    {2'd2, 32'h007, 16'h0000, 32'h0,        1'b0, 32'h000000CA, 4'h8}
  };

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    mem_rdata = '0;
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0;
    req_base = '0; req_imm = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    // R8 reset state
    check(req_ready == 1'b1, "R8 ready", 32'(req_ready), 32'h1);
    check(!rsp_done && !rsp_fault && !mem_en, "R8 idle outputs",
          {29'b0, rsp_done, rsp_fault, mem_en}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [31:0] base, src, expv, ea;
      logic [15:0] imm;
      logic        flt;
      logic [3:0]  be;
      {op, base, imm, src, flt, expv, be} = VEC[v];
      ea = base + {{16{imm[15]}}, imm};
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_imm = imm; req_wdata = src;
      #1;
      if (flt) begin
        check(rsp_fault && rsp_done, "R2 fault flag", {30'b0, rsp_fault, rsp_done}, 32'h3);
        check(rsp_fault_addr == expv, "R2 fault address", rsp_fault_addr, expv);
        check(!mem_en && !mem_we, "R3 no memory access", {30'b0, mem_en, mem_we}, 32'h0);
      end else begin
        check(!rsp_fault, op[1] ? "R9 byte never faults" : "R2 aligned word", 32'(rsp_fault), 32'h0);
        check(mem_en && mem_we == op[0], "R1 memory strobes", {30'b0, mem_en, mem_we}, {30'b0, 1'b1, op[0]});
        check(mem_addr == ea[31:2], "R1 effective address", {2'b0, mem_addr}, {2'b0, ea[31:2]});
        if (op[0]) begin
          logic [31:0] wexp;
          wexp = op[1] ? {4{src[7:0]}} : src;
          check(mem_be == be, op[1] ? "R5 lane enable" : "R7 lane enable", 32'(mem_be), 32'(be));
          check(mem_wdata == wexp, op[1] ? "R5 write data" : "R7 write data", mem_wdata, wexp);
          check(rsp_done && req_ready, "R7 store done at accept", {30'b0, rsp_done, req_ready}, 32'h3);
        end
      end
      @(negedge clk);
      if (!flt && !op[0]) begin
        check(rsp_done && !req_ready, "R6 load done next cycle", {30'b0, rsp_done, req_ready}, 32'h2);
        check(rsp_data == expv, op[1] ? "R4 byte load data" : "R6 word load data", rsp_data, expv);
      end
      req_valid = 1'b0;
    end

    @(negedge clk); #1;
    check(req_ready && !rsp_done, "R8 idle after traffic", {30'b0, req_ready, rsp_done}, 32'h2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule